// File: doc/BRIEF.md
# Migratory Coherence Cache-Cell Controller

This block governs the coherence state of a small set of cache cells that belong to one processor under a migratory protocol. The processor hands it one instruction at a time. There are four kinds: local load, local store, commit and reconcile. The controller either retires the instruction at once or holds it until the addressed cell reaches a state that allows retirement. When a load or store finds its address absent, the controller sends one cache-request message toward memory and marks the cell pending. It then waits for the matching data reply, which fills the cell and leaves it Clean.

Each address maps to exactly one cell, so no replacement takes place. Requests and replies travel over in-order channels. The cache stays silent toward memory while any cell is pending. The processor side uses valid/ready. An instruction that cannot retire keeps `proc_ready` low. The processor must then hold `proc_valid`, `proc_op`, `proc_addr` and `proc_wdata` unchanged until the handshake completes. The request channel is also valid/ready: `req_valid` and `req_addr` stay unchanged until memory raises `req_ready`. The reply channel never applies back-pressure.

Top module: `mig_cache_ctl`

## Requirements
- R1: After reset every cell is absent (state code 0), `req_valid` is 0 and `ret_valid` is 0.
- R2: A load (op code 0) on a Clean (state code 2) or Dirty (state code 3) cell is accepted in the cycle it is presented. One cycle after the handshake, `ret_valid` pulses for one cycle, with `ret_rdata` set to the cell data and `ret_cstate` set to the unchanged state.
- R3: A store (op code 1) on a Clean or Dirty cell is accepted at once and writes `proc_wdata`. Its retire reports `ret_cstate` = 3 (Dirty) and `ret_rdata` = the written data.
- R4: A commit (op code 2) or a reconcile (op code 3) retires at once on an absent, Clean or Dirty cell, and never produces a request. On an absent cell it reports `ret_rdata` = 0 and `ret_cstate` = 0. Otherwise it reports the cell's data and its unchanged state.
- R5: A load or store on an absent cell keeps `proc_ready` low. One cycle later `req_valid` rises with `req_addr` equal to the instruction's address, and the cell becomes pending (state code 1).
- R6: `req_valid` and `req_addr` hold until `req_ready` is seen. A new request never starts while any cell is pending, so at most one request is outstanding.
- R7: A reply (`rsp_valid`) addressed to a pending cell writes `rsp_data` into the cell and makes it Clean. The stalled instruction then retires: a load returns the reply data with state 2, and a store returns its own data with state 3.
- R8: `rsp_ready` is always 1. A reply addressed to a cell that is not pending leaves that cell's state and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor instruction present |
| proc_ready | output | 1 | Instruction may retire in this cycle |
| proc_op | input | 2 | 0 load, 1 store, 2 commit, 3 reconcile |
| proc_addr | input | AW | Cell address, AW = clog2(CELLS) |
| proc_wdata | input | DATA_W | Store data |
| ret_valid | output | 1 | One-cycle retire pulse |
| ret_rdata | output | DATA_W | Cell data after the instruction, 0 if absent |
| ret_cstate | output | 2 | Cell state after the instruction |
| req_valid | output | 1 | Cache request to memory present |
| req_ready | input | 1 | Memory takes the request |
| req_addr | output | AW | Address requested |
| rsp_valid | input | 1 | Data reply from memory present |
| rsp_ready | output | 1 | Reply accepted (tied to 1) |
| rsp_addr | input | AW | Address of the reply |
| rsp_data | input | DATA_W | Reply data |

## Verification
The properties assume that the processor holds a stalled instruction unchanged and that memory answers each accepted request exactly once, with a reply that carries that request's address. Stray replies may arrive, but only while no request is outstanding. The bench keeps to these rules. Its driver holds every instruction until `proc_ready` and only then lets it go. Its memory model answers each accepted request from an in-order queue after a random delay. Stray replies are injected only while the bench's own outstanding-request count is zero.

// File: rtl/mig_pkg.sv
package mig_pkg;

  typedef enum logic [1:0] {
    CS_ABSENT = 2'd0,
    CS_PEND   = 2'd1,
    CS_CLEAN  = 2'd2,
    CS_DIRTY  = 2'd3
  } cstate_e;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_RECON  = 2'd3
  } op_e;

  function automatic logic holds_data(cstate_e s);
    return (s == CS_CLEAN) || (s == CS_DIRTY);
  endfunction

  function automatic logic is_local(op_e o);
    return (o == OP_LOAD) || (o == OP_STORE);
  endfunction

endpackage

// File: rtl/mig_cell_bank.sv
module mig_cell_bank
  import mig_pkg::*;
#(
  parameter int CELLS  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output cstate_e           rd_state,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_we,
  input  logic [DATA_W-1:0] st_data,
  input  logic              pend_we,
  input  logic              fill_we,
  input  logic [AW-1:0]     fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_match,
  output logic              any_pend
);

  logic [CELLS-1:0][1:0]        st_v;
  logic [CELLS-1:0][DATA_W-1:0] d_v;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    cstate_e           st_q;
    logic [DATA_W-1:0] d_q;
    logic              sel_rd;
    logic              sel_fill;

    assign sel_rd   = (rd_addr == AW'(g));
    assign sel_fill = (fill_addr == AW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= CS_ABSENT;
        d_q  <= '0;
      end else if (fill_we && sel_fill && st_q == CS_PEND) begin
        st_q <= CS_CLEAN;
        d_q  <= fill_data;
      end else if (st_we && sel_rd) begin
        st_q <= CS_DIRTY;
        d_q  <= st_data;
      end else if (pend_we && sel_rd) begin
        st_q <= CS_PEND;
      end
    end

    assign st_v[g] = st_q;
    assign d_v[g]  = d_q;
  end

  assign rd_state   = cstate_e'(st_v[rd_addr]);
  assign rd_data    = d_v[rd_addr];
  assign fill_match = (st_v[fill_addr] == CS_PEND);

  always_comb begin
    any_pend = 1'b0;
    for (int i = 0; i < CELLS; i++) begin
      if (st_v[i] == CS_PEND) any_pend = 1'b1;
    end
  end

endmodule

// File: rtl/mig_retire_ctl.sv
module mig_retire_ctl
  import mig_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  op_e               in_op,
  input  logic [DATA_W-1:0] in_wdata,
  input  cstate_e           cell_state,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              any_pend,
  input  logic              req_busy,
  output logic              in_ready,
  output logic              st_we,
  output logic              issue,
  output logic              ret_valid,
  output logic [DATA_W-1:0] ret_rdata,
  output logic [1:0]        ret_cstate
);

  logic has_data;
  logic fire;

  assign has_data = holds_data(cell_state);

  always_comb begin
    unique case (in_op)
      OP_LOAD, OP_STORE:   in_ready = has_data;
      OP_COMMIT, OP_RECON: in_ready = has_data || (cell_state == CS_ABSENT);
      default:             in_ready = 1'b0;
    endcase
  end

  assign fire  = in_valid && in_ready;
  assign st_we = fire && (in_op == OP_STORE);
  assign issue = in_valid && is_local(in_op) && (cell_state == CS_ABSENT)
                 && !any_pend && !req_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid  <= 1'b0;
      ret_rdata  <= '0;
      ret_cstate <= CS_ABSENT;
    end else begin
      ret_valid <= fire;
      if (fire) begin
        if (in_op == OP_STORE) begin
          ret_rdata  <= in_wdata;
          ret_cstate <= CS_DIRTY;
        end else begin
          ret_rdata  <= has_data ? cell_data : '0;
          ret_cstate <= cell_state;
        end
      end
    end
  end

endmodule

// File: rtl/mig_req_port.sv
module mig_req_port #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_addr  <= issue_addr;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mig_cache_ctl.sv
module mig_cache_ctl
  import mig_pkg::*;
#(
  parameter int CELLS  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_valid,
  output logic              proc_ready,
  input  logic [1:0]        proc_op,
  input  logic [AW-1:0]     proc_addr,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic              ret_valid,
  output logic [DATA_W-1:0] ret_rdata,
  output logic [1:0]        ret_cstate,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [AW-1:0]     rsp_addr,
  input  logic [DATA_W-1:0] rsp_data
);

  cstate_e           cell_state;
  logic [DATA_W-1:0] cell_data;
  logic              st_we;
  logic              issue;
  logic              fill_match;
  logic              any_pend;

  assign rsp_ready = 1'b1;

  mig_cell_bank #(.CELLS(CELLS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (proc_addr),
    .rd_state  (cell_state),
    .rd_data   (cell_data),
    .st_we     (st_we),
    .st_data   (proc_wdata),
    .pend_we   (issue),
    .fill_we   (rsp_valid),
    .fill_addr (rsp_addr),
    .fill_data (rsp_data),
    .fill_match(fill_match),
    .any_pend  (any_pend)
  );

  mig_retire_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (proc_valid),
    .in_op     (op_e'(proc_op)),
    .in_wdata  (proc_wdata),
    .cell_state(cell_state),
    .cell_data (cell_data),
    .any_pend  (any_pend),
    .req_busy  (req_valid),
    .in_ready  (proc_ready),
    .st_we     (st_we),
    .issue     (issue),
    .ret_valid (ret_valid),
    .ret_rdata (ret_rdata),
    .ret_cstate(ret_cstate)
  );

  mig_req_port #(.AW(AW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_addr(proc_addr),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr)
  );

  // R2: every handshake yields exactly one retire pulse in the next cycle
  a_r2_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && proc_ready) |=> ret_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(proc_valid && proc_ready) |=> !ret_valid);

  // R3: a retired store always reports Dirty
  a_r3_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && proc_ready && proc_op == OP_STORE) |=> (ret_cstate == CS_DIRTY));

  // R5: a request that starts goes with a pending cell
  a_r5_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> any_pend);

  // R6: silent while pending, and request held under back-pressure
  a_r6_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(any_pend));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7: a reply to the pending cell clears the only pending state
  a_r7_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fill_match) |=> !any_pend);

  // R8: replies are always accepted
  a_r8_rsp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready);

endmodule

// File: tb/sim_mig_cache_ctl.sv
`timescale 1ns/1ps
module sim_mig_cache_ctl;

  localparam int CELLS  = 8;
  localparam int DATA_W = 32;
  localparam int AW     = $clog2(CELLS);

  typedef struct {
    logic [DATA_W-1:0] d;
    logic [1:0]        s;
    string             tag;
  } exp_t;

  typedef struct {
    logic [AW-1:0]     a;
    logic [DATA_W-1:0] d;
    bit                real_rsp;
  } rsp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              proc_valid = 1'b0;
  logic              proc_ready;
  logic [1:0]        proc_op = 2'd0;
  logic [AW-1:0]     proc_addr = '0;
  logic [DATA_W-1:0] proc_wdata = '0;
  logic              ret_valid;
  logic [DATA_W-1:0] ret_rdata;
  logic [1:0]        ret_cstate;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [AW-1:0]     req_addr;
  logic              rsp_valid = 1'b0;
  logic              rsp_ready;
  logic [AW-1:0]     rsp_addr = '0;
  logic [DATA_W-1:0] rsp_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int outstanding = 0;
  bit rsp_busy = 1'b0;

  exp_t exp_q[$];
  rsp_t rsp_q[$];

  int                m_st [CELLS];
  logic [DATA_W-1:0] m_d  [CELLS];

  always #4 clk = ~clk;

  mig_cache_ctl #(.CELLS(CELLS), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .proc_valid(proc_valid), .proc_ready(proc_ready), .proc_op(proc_op),
    .proc_addr(proc_addr), .proc_wdata(proc_wdata),
    .ret_valid(ret_valid), .ret_rdata(ret_rdata), .ret_cstate(ret_cstate),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data)
  );

  function automatic logic [DATA_W-1:0] memval(int a);
    return 32'hC0DE_0000 | DATA_W'(a * 17 + 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // retire monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected retire", ret_rdata, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ret_rdata == e.d, {e.tag, " data"}, ret_rdata, e.d);
        chk(ret_cstate == e.s, {e.tag, " state"}, DATA_W'(ret_cstate), DATA_W'(e.s));
      end
    end
  end

  // request monitor: acceptance happens at the coming edge
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      chk(outstanding == 0, "R6 second outstanding request", DATA_W'(outstanding), '0);
      outstanding++;
      rsp_q.push_back('{a: req_addr, d: memval(int'(req_addr)), real_rsp: 1'b1});
    end
  end

  // memory back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      req_ready = ($urandom % 3) != 0;
    end
  end

  // memory responder, in order, random delay
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_q.size() != 0) begin
        rsp_t r;
        int dly;
        r = rsp_q.pop_front();
        rsp_busy = 1'b1;
        dly = $urandom % 7;
        repeat (dly) @(posedge clk);
        @(posedge clk); #1;
        rsp_valid = 1'b1;
        rsp_addr  = r.a;
        rsp_data  = r.d;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        if (r.real_rsp) outstanding--;
        rsp_busy = 1'b0;
      end
    end
  end

  task automatic do_op(input int op, input int a, input logic [DATA_W-1:0] wd);
    bit miss;
    exp_t e;
    int waitc;
    miss = (op < 2) && (m_st[a] == 0);
    if (op == 1) begin
      m_st[a] = 3; m_d[a] = wd;
      e = '{d: wd, s: 2'd3, tag: miss ? "R7 store after fill" : "R3 store"};
    end else if (op == 0) begin
      if (miss) begin m_st[a] = 2; m_d[a] = memval(a); end
      e = '{d: m_d[a], s: 2'(m_st[a]), tag: miss ? "R7 load after fill" : "R2 load"};
    end else begin
      e = '{d: (m_st[a] == 0) ? '0 : m_d[a], s: 2'(m_st[a]), tag: "R4 commit/reconcile"};
    end
    exp_q.push_back(e);
    @(posedge clk); #1;
    proc_valid = 1'b1;
    proc_op    = 2'(op);
    proc_addr  = AW'(a);
    proc_wdata = wd;
    waitc = 0;
    forever begin
      @(negedge clk);
      if (miss && waitc == 0)
        chk(!proc_ready, "R5 stall on absent", DATA_W'(proc_ready), '0);
      if (miss && waitc == 1) begin
        chk(req_valid == 1'b1, "R5 request raised", DATA_W'(req_valid), 1);
        chk(req_addr == AW'(a), "R5 request address", DATA_W'(req_addr), DATA_W'(a));
      end
      if (!miss && waitc == 0)
        chk(proc_ready, "R2/R3/R4 immediate retire", DATA_W'(proc_ready), 1);
      if (proc_ready) break;
      waitc++;
      if (waitc > 300) begin
        chk(1'b0, "R7 pending never filled", '0, 1);
        break;
      end
    end
    @(posedge clk); #1;
    proc_valid = 1'b0;
  endtask

  task automatic stray(input int a, input logic [DATA_W-1:0] d);
    rsp_q.push_back('{a: AW'(a), d: d, real_rsp: 1'b0});
    @(negedge clk);
    while (rsp_q.size() != 0 || rsp_busy) @(negedge clk);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 50) begin @(negedge clk); n++; end
  endtask

  initial begin
    for (int i = 0; i < CELLS; i++) begin m_st[i] = 0; m_d[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid after reset", DATA_W'(req_valid), 0);
    chk(ret_valid == 1'b0, "R1 ret_valid after reset", DATA_W'(ret_valid), 0);
    chk(rsp_ready == 1'b1, "R8 rsp_ready", DATA_W'(rsp_ready), 1);
    // R1/R4: every cell absent, commit retires without request
    for (int i = 0; i < CELLS; i++) do_op(2, i, '0);
    do_op(3, 1, '0);
    chk(req_valid == 1'b0 && outstanding == 0, "R4 no request from commit",
        DATA_W'(req_valid), 0);
    // R5/R7 load miss then hit
    do_op(0, 2, '0);
    do_op(0, 2, '0);
    // R3 store on clean, then read back and commit on dirty
    do_op(1, 2, 32'h1234_5678);
    do_op(0, 2, '0);
    do_op(2, 2, '0);
    do_op(3, 2, '0);
    // R7 store miss
    do_op(1, 5, 32'hDEAD_BEEF);
    do_op(0, 5, '0);
    drain();
    // R8 stray replies leave cells untouched
    stray(2, 32'hBAD0_0001);
    do_op(0, 2, '0);
    stray(6, 32'hBAD0_0002);
    do_op(2, 6, '0);
    do_op(0, 6, '0);
    // random traffic
    for (int k = 0; k < 200; k++)
      do_op(int'($urandom % 4), int'($urandom % CELLS), $urandom);
    drain();
    chk(exp_q.size() == 0, "R2 all retires seen", DATA_W'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule